// File: doc/BRIEF.md
# I2C Register Slave with Aliased 64-Byte Space

This block is a two-wire serial control slave that runs from a fast system clock and oversamples the bus lines. It holds a 64-byte register space reached through an 8-bit index. Only the low six bits of the index select a register, so indices from 0x40 up to 0xFF fold back onto 0x00–0x3F. A write transfer sets the index and then stores any number of data bytes. A read transfer sets the index, issues a repeated START and then returns bytes. In both cases the index steps by one after each byte.

The slave answers one 7-bit bus address. By default two strap pins pick it. Register 0x00 can replace it with an address written by software. Registers 0x00–0x2F are writable storage: each one has a write mask, and its bits are brought out to the rest of the chip as a flat configuration vector. Registers 0x30–0x3F are fixed constants: identification bytes and a revision code.

Each bus line passes through a two-flop synchronizer and a glitch filter before the protocol engine sees it. SDA is driven open-drain: the block only pulls the line low or lets it go. Clock stretching and the pads are outside the block.

Top module: `i2cr_slave`

## Requirements
- R1: With the override off, the 7-bit address follows `strap_id`: 00 selects 0x3C, 01 selects 0x3D, 10 selects 0x36, 11 selects 0x37. A matching address byte is ACKed (SDA held low in the ninth clock).
- R2: Register 0x00 holds an override address in bits [7:1]; its reset value is 0x60, which gives 0x30. While bit 0 is 1, the slave answers that address and no longer answers the strap address.
- R3: START (SDA falls while SCL high) begins address reception from any state, so a repeated START inside a transfer is accepted. STOP (SDA rises while SCL high) ends the transfer. Bits clocked after a STOP and without a new START are not ACKed.
- R4: A write is address+0, then an index byte, then data bytes. Every byte is ACKed, and each data byte lands at the current index, which then steps by one.
- R5: A read is an index write, a repeated START, then address+1. Bytes come MSB first from consecutive indices. A master ACK requests the next byte; a master NACK ends the read.
- R6: An address byte that does not match is not ACKed (SDA released). The bytes that follow are not ACKed and change no register.
- R7: Only index bits [5:0] select a register, so 0x40–0xFF alias onto 0x00–0x3F. Auto-increment runs from 0x3F to 0x00.
- R8: Registers 0x30–0x35 read 0x49, 0x32, 0x43, 0x52, 0x45, 0x47. Registers 0x36 and 0x3B read 0x01. All other registers from 0x30 to 0x3F read 0x00. Writes to 0x30–0x3F are ignored.
- R9: Write masks are 0xAF for 0x01, 0x37 for 0x02, 0xF0 for 0x03, and 0xFF for 0x00 and for 0x04–0x2F. Masked-off bits read back 0. Reset values are 0x60 for 0x00, 0x04 for 0x02, and 0x00 for all others. `cfg_regs[8k+7:8k]` carries register k, for k = 0 to 47.
- R10: A pulse shorter than 3 system clocks on SCL or SDA is ignored.
- R11: `sda_pull_low` is the only SDA output. It rises only while the filtered SCL is low, and it is never active during bits the master drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 25 times the bus bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_id | input | 2 | Address select straps |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_pull_low | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_regs | output | 384 | Writable registers 0x00–0x2F, register k in bits [8k+7:8k] |

## Verification
Properties checked on every cycle:
- The slave pulls SDA only while the clean SCL is low.
- A STOP releases the line and idles the engine.
- A START always leads to address reception.
- Every stored byte advances the index by one.
- A masked write keeps its reserved bits at their fixed value.
- A write aimed at the constant area leaves all storage untouched.
- A filter output holds whenever its synchronized input agrees with it.

Only the bench scenarios can show the end-to-end behaviour:
- the strap table and the override taking effect;
- the byte order of sequential reads and the index wrap past 0x3F;
- the identification constants;
- the fact that short pulses placed inside a live transfer leave the stored data unharmed.

// File: rtl/i2cr_pkg.sv
// Package: shared constants, state type and the register-map functions
// (write masks, reset values, read-only constants, strap address table).
// Assumes a 64-entry space whose lower 48 entries are writable storage.
package i2cr_pkg;
    localparam int REG_SPACE  = 64;
    localparam int RW_REGS    = 48;
    localparam int IDX_W      = $clog2(REG_SPACE);
    localparam int BYTE_W     = 8;
    localparam int BITCNT_W   = $clog2(BYTE_W);
    localparam logic [6:0] OVR_ADDR_DEF = 7'h30;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_IDX, S_WDATA, S_ACK_WAIT, S_ACK_HOLD, S_RDATA, S_RACK
    } bus_state_t;

    // Writable bit mask of each storage register.
    function automatic logic [7:0] reg_wmask(input int a);
        case (a)
            1:       return 8'hAF;
            2:       return 8'h37;
            3:       return 8'hF0;
            default: return (a < RW_REGS) ? 8'hFF : 8'h00;
        endcase
    endfunction

    // Reset value of each storage register.
    function automatic logic [7:0] reg_reset(input int a);
        case (a)
            0:       return {OVR_ADDR_DEF, 1'b0};
            2:       return 8'h04;
            default: return 8'h00;
        endcase
    endfunction

    // Fixed content of the read-only upper area.
    function automatic logic [7:0] ro_byte(input int a);
        case (a)
            48:      return 8'h49;
            49:      return 8'h32;
            50:      return 8'h43;
            51:      return 8'h52;
            52:      return 8'h45;
            53:      return 8'h47;
            54, 59:  return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    // Bus address chosen by the strap pins.
    function automatic logic [6:0] strap_addr(input logic [1:0] s);
        case (s)
            2'b00:   return 7'h3C;
            2'b01:   return 7'h3D;
            2'b10:   return 7'h36;
            default: return 7'h37;
        endcase
    endfunction
endpackage

// File: rtl/i2cr_deglitch.sv
// Line conditioner: two-flop synchronizer followed by a persistence filter.
// The clean output takes a new level only after the synchronized input has
// disagreed with it for FILT_LEN consecutive clocks. Idles high (bus idle).
module i2cr_deglitch #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic       s1, s2;
    logic [CW-1:0] cnt;

    // Synchronize the asynchronous pad level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= raw_in;
            s2 <= s1;
        end
    end

    // Accept a new level only after it persists for FILT_LEN clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= 1'b1;
            cnt   <= '0;
        end else if (s2 == clean) begin
            cnt <= '0;
        end else if (cnt == CW'(FILT_LEN - 1)) begin
            clean <= s2;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R10: output never moves while the synchronized input agrees with it
    p_filt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s2 == clean) |=> $stable(clean));
endmodule

// File: rtl/i2cr_regs.sv
// Register space: 48 masked storage registers plus a read-only constant area.
// The index is already folded to 6 bits by the caller. Also selects the bus
// address from the straps or the override held in register 0.
module i2cr_regs
    import i2cr_pkg::*;
#(
    parameter int RW_COUNT = RW_REGS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_slot,
    input  logic [BYTE_W-1:0]       wr_data,
    input  logic [IDX_W-1:0]        rd_slot,
    output logic [BYTE_W-1:0]       rd_data,
    input  logic [1:0]              strap_id,
    output logic [6:0]              dev_addr,
    output logic [RW_COUNT*BYTE_W-1:0] store_flat
);
    // One masked storage byte per writable register.
    for (genvar g = 0; g < RW_COUNT; g++) begin : g_reg
        localparam logic [7:0] M   = reg_wmask(g);
        localparam logic [7:0] RST = reg_reset(g);
        logic [7:0] q;

        // Load writable bits on a matching write; reserved bits keep their value.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= RST;
            else if (wr_en && wr_slot == IDX_W'(g))
                q <= (q & ~M) | (wr_data & M);
        end

        assign store_flat[g*BYTE_W +: BYTE_W] = q;

        // R9: a write takes only the masked bits; reserved bits stay fixed
        p_masked_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_slot == IDX_W'(g)) |=>
                ((q & M) == ($past(wr_data) & M)) && ((q & ~M) == (RST & ~M)));
    end

    // Read mux: storage below RW_COUNT, constants above.
    always_comb begin
        rd_data = ro_byte(int'(rd_slot));
        for (int k = 0; k < RW_COUNT; k++) begin
            if (rd_slot == IDX_W'(k))
                rd_data = store_flat[k*BYTE_W +: BYTE_W];
        end
    end

    // Address select: override when bit 0 of register 0 is set.
    assign dev_addr = store_flat[0] ? store_flat[7:1] : strap_addr(strap_id);

    // R8: writes into the constant area leave every storage byte unchanged
    p_ro_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slot >= IDX_W'(RW_COUNT)) |=> $stable(store_flat));
endmodule

// File: rtl/i2cr_link.sv
// Bus protocol engine working on filtered SCL/SDA levels. Detects START and
// STOP, shifts address/index/data bytes in on SCL rise, drives ACK and read
// bits after SCL fall, and keeps the 6-bit auto-incrementing index.
// Assumes each SCL phase lasts well beyond the filter latency.
module i2cr_link
    import i2cr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [6:0]        dev_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [IDX_W-1:0]  idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_low
);
    logic scl_q, sda_q;
    logic scl_rise, scl_fall, start_det, stop_det;
    bus_state_t state, nxt;
    logic [BITCNT_W-1:0] bitcnt;
    logic [BYTE_W-2:0]   shreg;
    logic [BYTE_W-1:0]   tx, rx_byte;
    logic                mack;

    // Remember the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  = !scl_q && scl_f;
    assign scl_fall  = scl_q && !scl_f;
    assign start_det = scl_q && scl_f && sda_q && !sda_f;
    assign stop_det  = scl_q && scl_f && !sda_q && sda_f;
    assign rx_byte   = {shreg, sda_f};

    // Protocol state machine, shifter, index and line drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            nxt     <= S_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            tx      <= '0;
            idx     <= '0;
            sda_low <= 1'b0;
            mack    <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= S_ADDR;
                bitcnt  <= '0;
                sda_low <= 1'b0;
            end else if (stop_det) begin
                state   <= S_IDLE;
                sda_low <= 1'b0;
            end else begin
                case (state)
                    S_ADDR, S_IDX, S_WDATA: begin
                        if (scl_rise) begin
                            shreg  <= rx_byte[BYTE_W-2:0];
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == BITCNT_W'(BYTE_W - 1)) begin
                                if (state == S_ADDR) begin
                                    if (rx_byte[7:1] == dev_addr) begin
                                        state <= S_ACK_WAIT;
                                        nxt   <= rx_byte[0] ? S_RDATA : S_IDX;
                                    end else begin
                                        state <= S_IDLE;
                                    end
                                end else if (state == S_IDX) begin
                                    idx   <= rx_byte[IDX_W-1:0];
                                    state <= S_ACK_WAIT;
                                    nxt   <= S_WDATA;
                                end else begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= idx;
                                    wr_data <= rx_byte;
                                    idx     <= idx + 1'b1;
                                    state   <= S_ACK_WAIT;
                                    nxt     <= S_WDATA;
                                end
                            end
                        end
                    end
                    S_ACK_WAIT: begin
                        if (scl_fall) begin
                            sda_low <= 1'b1;
                            state   <= S_ACK_HOLD;
                        end
                    end
                    S_ACK_HOLD: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (nxt == S_RDATA) begin
                                tx      <= rd_data;
                                sda_low <= !rd_data[BYTE_W-1];
                                idx     <= idx + 1'b1;
                                state   <= S_RDATA;
                            end else begin
                                sda_low <= 1'b0;
                                state   <= nxt;
                            end
                        end
                    end
                    S_RDATA: begin
                        if (scl_fall) begin
                            if (bitcnt == BITCNT_W'(BYTE_W - 1)) begin
                                sda_low <= 1'b0;
                                bitcnt  <= '0;
                                state   <= S_RACK;
                            end else begin
                                tx      <= {tx[BYTE_W-2:0], 1'b0};
                                sda_low <= !tx[BYTE_W-2];
                                bitcnt  <= bitcnt + 1'b1;
                            end
                        end
                    end
                    S_RACK: begin
                        if (scl_rise) begin
                            mack <= !sda_f;
                        end else if (scl_fall) begin
                            if (mack) begin
                                tx      <= rd_data;
                                sda_low <= !rd_data[BYTE_W-1];
                                idx     <= idx + 1'b1;
                                bitcnt  <= '0;
                                state   <= S_RDATA;
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: the slave starts pulling SDA only while SCL is low
    p_pull_on_low_scl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low) |-> !scl_f);

    // R3: a STOP releases the line and idles the engine
    p_stop_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_low && state == S_IDLE));

    // R3: a START always leads to address reception
    p_start_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_ADDR));

    // R4: each stored byte advances the index by exactly one
    p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (idx == wr_idx + IDX_W'(1)));
endmodule

// File: rtl/i2cr_slave.sv
// Top: conditions both bus lines, runs the protocol engine and holds the
// register space. SDA output is a pull-low enable for an open-drain pad.
module i2cr_slave
    import i2cr_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 strap_id,
    input  logic                       scl_in,
    input  logic                       sda_in,
    output logic                       sda_pull_low,
    output logic [RW_REGS*BYTE_W-1:0]  cfg_regs
);
    logic [1:0]        raw, filt;
    logic [IDX_W-1:0]  idx, wr_idx;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data, rd_data;
    logic [6:0]        dev_addr;

    assign raw = {scl_in, sda_in};

    // One conditioner per bus line: bit 1 is SCL, bit 0 is SDA.
    for (genvar n = 0; n < 2; n++) begin : g_line
        i2cr_deglitch #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_in (raw[n]),
            .clean  (filt[n])
        );
    end

    i2cr_link u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (filt[1]),
        .sda_f    (filt[0]),
        .dev_addr (dev_addr),
        .rd_data  (rd_data),
        .idx      (idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sda_low  (sda_pull_low)
    );

    i2cr_regs #(.RW_COUNT(RW_REGS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_slot    (wr_idx),
        .wr_data    (wr_data),
        .rd_slot    (idx),
        .rd_data    (rd_data),
        .strap_id   (strap_id),
        .dev_addr   (dev_addr),
        .store_flat (cfg_regs)
    );
endmodule

// File: tb/sim_i2cr_slave.sv
// Bench: a behavioural bus master plus a register-space model. The model is
// compared with cfg_regs and the SDA drive on every clock while the bus idles.
module sim_i2cr_slave;
    localparam int NRW = 48;
    localparam int Q   = 12;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic [1:0] strap = 2'b00;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_bus, sda_pull_low;
    logic [NRW*8-1:0] cfg;
    assign sda_bus = sda_m & ~sda_pull_low;

    i2cr_slave u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_id     (strap),
        .scl_in       (scl_m),
        .sda_in       (sda_bus),
        .sda_pull_low (sda_pull_low),
        .cfg_regs     (cfg)
    );

    int vectors = 0, errs = 0, cyc = 0;
    logic [7:0] model [64];
    bit idle = 1'b1, glitch = 1'b0, drv_seen = 1'b0, done = 1'b0;

    function automatic logic [7:0] f_mask(input int a);
        if (a == 1) return 8'hAF;
        if (a == 2) return 8'h37;
        if (a == 3) return 8'hF0;
        return (a < NRW) ? 8'hFF : 8'h00;
    endfunction

    function automatic logic [7:0] f_def(input int a);
        return (a == 0) ? 8'h60 : (a == 2) ? 8'h04 : 8'h00;
    endfunction

    function automatic logic [7:0] f_const(input int a);
        logic [7:0] idb [6] = '{8'h49, 8'h32, 8'h43, 8'h52, 8'h45, 8'h47};
        if (a >= 48 && a <= 53) return idb[a-48];
        if (a == 54 || a == 59) return 8'h01;
        return 8'h00;
    endfunction

    function automatic logic [6:0] strap_tab(input logic [1:0] s);
        case (s)
            2'b00: return 7'h3C;
            2'b01: return 7'h3D;
            2'b10: return 7'h36;
            default: return 7'h37;
        endcase
    endfunction

    function automatic logic [6:0] cur_addr();
        return model[0][0] ? model[0][7:1] : strap_tab(strap);
    endfunction

    function automatic void mwrite(input int i, input logic [7:0] d);
        int s = i & 63;
        if (s < NRW) model[s] = d & f_mask(s);
    endfunction

    function automatic logic [7:0] mread(input int i);
        int s = i & 63;
        return (s < NRW) ? model[s] : f_const(s);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of storage and SDA drive while the bus idles.
    always @(negedge clk) begin
        if (rst_n && idle && !done) begin
            for (int k = 0; k < NRW; k++)
                chk($sformatf("R9 cfg reg %0h", k), int'(cfg[k*8 +: 8]), int'(model[k]));
            chk("R11 idle release", int'(sda_pull_low), 0);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errs++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bstart();
        if (!scl_m) begin sda_m = 1'b1; q(); scl_m = 1'b1; q(); end
        sda_m = 1'b0; q(); scl_m = 1'b0; q();
    endtask

    task automatic bstop();
        sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
    endtask

    task automatic wbit(input bit b);
        sda_m = b;
        if (glitch) begin
            repeat (4) @(negedge clk); scl_m = 1'b1;
            repeat (2) @(negedge clk); scl_m = 1'b0;
            repeat (Q-6) @(negedge clk);
        end else q();
        scl_m = 1'b1;
        if (glitch) begin
            repeat (4) @(negedge clk); sda_m = !b;
            repeat (2) @(negedge clk); sda_m = b;
            repeat (Q-6) @(negedge clk);
        end else q();
        if (sda_pull_low) drv_seen = 1'b1;
        q(); scl_m = 1'b0; q();
    endtask

    task automatic rbit(output bit b);
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_bus; q(); scl_m = 1'b0; q();
    endtask

    task automatic send(input logic [7:0] d, output bit ack);
        bit b;
        drv_seen = 1'b0;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        chk("R11 no pull during master bits", int'(drv_seen), 0);
        rbit(b);
        ack = !b;
    endtask

    task automatic recv(input bit mack, output logic [7:0] d);
        bit b;
        for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
        wbit(!mack);
    endtask

    task automatic wr(input string tag, input logic [6:0] a, input logic [7:0] idx,
                      input int n, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2);
        logic [7:0] bytes [3];
        bit ack, exp;
        bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
        exp = (a == cur_addr());
        idle = 1'b0;
        bstart();
        send({a, 1'b0}, ack); chk({tag, " address ack"}, int'(ack), int'(exp));
        send(idx, ack);       chk({tag, " index ack"}, int'(ack), int'(exp));
        for (int i = 0; i < n; i++) begin
            send(bytes[i], ack); chk({tag, " data ack"}, int'(ack), int'(exp));
            if (exp) mwrite(idx + i, bytes[i]);
        end
        bstop();
        idle = 1'b1;
    endtask

    task automatic rd(input string tag, input logic [6:0] a, input logic [7:0] idx, input int n);
        bit ack;
        logic [7:0] d;
        idle = 1'b0;
        bstart();
        send({a, 1'b0}, ack); chk({tag, " address ack"}, int'(ack), 1);
        send(idx, ack);       chk({tag, " index ack"}, int'(ack), 1);
        bstart();
        send({a, 1'b1}, ack); chk({tag, " read address ack"}, int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            recv(i < n - 1, d);
            chk($sformatf("%s byte %0d", tag, i), int'(d), int'(mread(idx + i)));
        end
        bstop();
        idle = 1'b1;
    endtask

    initial begin
        bit ack;
        for (int s = 0; s < 64; s++) model[s] = f_def(s);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 reset reg 0x00", int'(cfg[7:0]), 8'h60);
        chk("R9 reset reg 0x02", int'(cfg[23:16]), 8'h04);
        chk("R11 reset release", int'(sda_pull_low), 0);

        // R4 burst write and R5 sequential read back
        wr("R4 burst write", 7'h3C, 8'h05, 3, 8'hA5, 8'h5A, 8'hFF);
        rd("R5 burst read", 7'h3C, 8'h05, 3);
        rd("R2 default override reg", 7'h3C, 8'h00, 1);

        // R6 wrong address: NACK, following bytes ignored
        wr("R6 mismatch", 7'h3D, 8'h05, 2, 8'h11, 8'h22, 8'h00);

        // R1 strap table
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            wr("R1 strap address", strap_tab(2'(s)), 8'(8'h10 + s), 1, 8'(s + 1), 8'h00, 8'h00);
        end
        strap = 2'b00;
        rd("R1 strap writes", 7'h3C, 8'h10, 4);

        // R9 masks
        wr("R9 masked write", 7'h3C, 8'h01, 3, 8'hFF, 8'hFF, 8'hFF);
        rd("R9 masked read", 7'h3C, 8'h01, 3);

        // R7 aliasing and wrap
        wr("R7 alias write", 7'h3C, 8'h45, 1, 8'h9C, 8'h00, 8'h00);
        rd("R7 alias read", 7'h3C, 8'hC5, 1);
        rd("R7 wrap read", 7'h3C, 8'h3F, 2);
        wr("R7 write into const", 7'h3C, 8'h2F, 2, 8'h12, 8'h34, 8'h00);

        // R8 identification and revision bytes
        wr("R8 const write", 7'h3C, 8'h31, 1, 8'h00, 8'h00, 8'h00);
        rd("R8 id bytes", 7'h3C, 8'h30, 7);
        rd("R8 revision", 7'h3C, 8'h3B, 1);

        // R2 override address
        wr("R2 set override", 7'h3C, 8'h00, 1, 8'h61, 8'h00, 8'h00);
        chk("R2 override stored", int'(cfg[7:0]), 8'h61);
        wr("R2 strap now ignored", 7'h3C, 8'h06, 1, 8'h77, 8'h00, 8'h00);
        wr("R2 override address", 7'h30, 8'h06, 1, 8'h78, 8'h00, 8'h00);
        rd("R2 override read", 7'h30, 8'h06, 1);
        wr("R2 clear override", 7'h30, 8'h00, 1, 8'h60, 8'h00, 8'h00);

        // R10 short pulses on both lines inside a live write
        glitch = 1'b1;
        wr("R10 glitched write", 7'h3C, 8'h20, 2, 8'hC3, 8'h3C, 8'h00);
        glitch = 1'b0;
        rd("R10 after glitches", 7'h3C, 8'h20, 2);

        // R3 repeated START inside a write, then bits after STOP
        idle = 1'b0;
        bstart();
        send(8'h78, ack); chk("R3 first address ack", int'(ack), 1);
        send(8'h08, ack); chk("R3 first index ack", int'(ack), 1);
        send(8'h11, ack); chk("R3 first data ack", int'(ack), 1); mwrite(8, 8'h11);
        bstart();
        send(8'h78, ack); chk("R3 repeated start address ack", int'(ack), 1);
        send(8'h09, ack); chk("R3 second index ack", int'(ack), 1);
        send(8'h22, ack); chk("R3 second data ack", int'(ack), 1); mwrite(9, 8'h22);
        bstop();
        q(); scl_m = 1'b0; q();
        send(8'h78, ack); chk("R3 no ack after stop", int'(ack), 0);
        bstop();
        idle = 1'b1;
        rd("R3 repeated start data", 7'h3C, 8'h08, 2);

        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule